// File: doc/BRIEF.md
# Two-Way Conversion Sequencer for a Shared ADC

This block walks a single analog-to-digital converter through a programmed list of channel conversions. Software, an external start pin or one of two event inputs starts a sequence. The block then issues one conversion request per slot. Each request carries the channel held in that slot's select field. The block writes each returned sample into the result register of the same slot. When the last slot of the sequence completes, the sequencer goes idle or restarts, and it raises its interrupt flag according to its interrupt mode.

The block has two modes. In split mode there are two independent sequencers: A owns slots 0 to 7 and B owns slots 8 to 15. If both want the converter, A takes it first. In cascaded mode A runs alone over all sixteen slots and B is idle. Configuration is written through a plain write port. The results are read combinationally through an index port. Sequencer state (busy, interrupt, alternation bit, slot pointer and remaining count) is brought out directly.

Top module: `adc_autoseq`

## Requirements
- R1: Bit 0 of address 0 selects cascaded mode when 1. In cascaded mode sequencer A alone uses slots 0-15 and sequencer B stays idle and ignores every trigger. When the bit is 0, A uses slots 0-7 and B uses slots 8-15.
- R2: The channel for slot k is read from address 4+(k/4), bits 4*(k%4)+3 down to 4*(k%4). The conversion request for that slot carries this channel on `conv_chan`.
- R3: The length field is bits 11:8 of a sequencer's control word (A at address 1, B at address 2). A value N gives N+1 conversions. A uses all four bits only in cascaded mode. In split mode A and B each use only bits 10:8.
- R4: When the conversion for slot i returns, the 12-bit sample is stored left-justified (sample in bits 15:4, bits 3:0 zero) in result register i. The result is readable at `rd_data` when `rd_idx` = i.
- R5: When a sequence starts, the remaining count is loaded with N. It drops by one after each conversion and reads 0 at the end and while idle. The pointer shows the absolute slot being converted and reads the sequencer's first slot when idle (0 for A, 8 for B).
- R6: Busy reads 1 from the clock edge that accepts a trigger until the end of the sequence, and 0 while the sequencer waits for a trigger.
- R7: Control bit 4 selects the interrupt mode. With 0, the interrupt flag is set at every end of sequence. With 1, the alternation bit toggles at each end of sequence and the flag is set only at the end where the alternation bit was already 1, so the flag is set every second end.
- R8: Writing a control word with bit 5 set clears that sequencer's interrupt flag. A control write with bit 5 clear leaves the flag unchanged.
- R9: Writing a control word with bit 1 set returns the sequencer at once to idle: busy 0, pointer at its first slot, count 0, alternation bit 0, no pending start. The result of a conversion in flight for it is dropped.
- R10: A sequence is started by control bit 0, by `ext_soc` for A when control bit 2 is 1, or by its event input (`evt_a` or `evt_b`) when control bit 3 is 1. A gated input whose enable is 0 has no effect.
- R11: Bit 1 of address 0 selects continuous running. In continuous running a sequencer restarts from its first slot right after its end of sequence.
- R12: In split mode, when both sequencers wait for the converter, A is served first. A trigger that arrives while a sequencer is busy is held and starts one more sequence right after the current one ends.
- R13: `conv_start` is a one-cycle pulse. No new request is issued until `conv_done` returns for the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 4 | Write address (0 mode, 1 control A, 2 control B, 4-7 channel selects) |
| wr_data | input | 16 | Write data |
| ext_soc | input | 1 | External start for sequencer A |
| evt_a | input | 1 | Event start for sequencer A |
| evt_b | input | 1 | Event start for sequencer B |
| conv_start | output | 1 | Conversion request pulse |
| conv_chan | output | 4 | Channel of the requested conversion |
| conv_done | input | 1 | Conversion complete pulse |
| conv_data | input | 12 | Conversion sample, valid with conv_done |
| rd_idx | input | 4 | Result register index |
| rd_data | output | 16 | Selected result register |
| busy | output | 2 | Busy per sequencer (bit 0 A, bit 1 B) |
| irq | output | 2 | Interrupt flag per sequencer |
| eos_buf | output | 2 | Alternation bit per sequencer |
| ptr_a | output | 4 | Slot pointer of A |
| ptr_b | output | 4 | Slot pointer of B (absolute slot) |
| remain_a | output | 4 | Conversions still to go for A |
| remain_b | output | 4 | Conversions still to go for B |

## Verification
The checker assumes the converter model raises `conv_done` for exactly one cycle, and only after a request is outstanding. It also assumes that the mode bit is not changed while sequencer B is mid-sequence. The stimulus keeps within these limits in three ways. The bench converter answers each observed request once, after a fixed latency. Every mode change is made while both sequencers are idle. Triggers are placed only at clock-safe points between edges. Under these conditions the interrupt-flag, idle-count, pointer-range and single-outstanding properties must hold.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;
    localparam int SLOTS  = 16;
    localparam int CHW    = 4;
    localparam int DW     = 12;
    localparam int RW     = 16;
    localparam int SW     = $clog2(SLOTS);
    localparam int HALF   = SLOTS / 2;
    localparam int NCHREG = (SLOTS * CHW) / RW;

    localparam logic [3:0] ADDR_CFG   = 4'd0;
    localparam logic [3:0] ADDR_CTL_A = 4'd1;
    localparam logic [3:0] ADDR_CHSEL = 4'd4;

    localparam int B_CASCADE = 0;
    localparam int B_CONT    = 1;
    localparam int B_START   = 0;
    localparam int B_RESET   = 1;
    localparam int B_EXT_EN  = 2;
    localparam int B_EVT_EN  = 3;
    localparam int B_IRQ_MOD = 4;
    localparam int B_CLR     = 5;
    localparam int MAX_LSB   = 8;

    typedef struct packed {
        logic          ext_en;
        logic          evt_en;
        logic          irq_mode;
        logic [SW-1:0] max_cnt;
    } seq_cfg_t;

    function automatic seq_cfg_t ctl_decode(input logic [RW-1:0] w);
        seq_cfg_t c;
        c.ext_en   = w[B_EXT_EN];
        c.evt_en   = w[B_EVT_EN];
        c.irq_mode = w[B_IRQ_MOD];
        c.max_cnt  = w[MAX_LSB +: SW];
        return c;
    endfunction

    function automatic logic [CHW-1:0] chsel_field(input logic [SLOTS*CHW-1:0] flat,
                                                   input logic [SW-1:0] slot);
        return flat[slot*CHW +: CHW];
    endfunction

    function automatic logic [RW-1:0] left_just(input logic [DW-1:0] d);
        return {d, {(RW-DW){1'b0}}};
    endfunction
endpackage

// File: rtl/adc_seq_unit.sv
`timescale 1ns/1ps
module adc_seq_unit
    import adc_seq_pkg::*;
#(
    parameter logic [SW-1:0] BASE = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic          trig,
    input  logic          seq_rst,
    input  logic          cont,
    input  logic          irq_mode,
    input  logic          clr,
    input  logic [SW-1:0] max_cnt,
    input  logic          done,
    output logic          busy,
    output logic [SW-1:0] ptr,
    output logic [SW-1:0] rem,
    output logic          irq,
    output logic          eosb,
    output logic          eos
);
    logic pend;

    assign eos = done && (rem == '0);

    always_ff @(posedge clk) begin
        if (rst || !active || seq_rst) begin
            busy <= 1'b0;
            ptr  <= BASE;
            rem  <= '0;
            pend <= 1'b0;
            eosb <= 1'b0;
        end else begin
            if (done) begin
                if (rem == '0) begin
                    ptr  <= BASE;
                    pend <= 1'b0;
                    if (cont || pend || trig) begin
                        rem <= max_cnt;
                    end else begin
                        busy <= 1'b0;
                    end
                    if (irq_mode) eosb <= ~eosb;
                end else begin
                    ptr <= ptr + 1'b1;
                    rem <= rem - 1'b1;
                    if (trig) pend <= 1'b1;
                end
            end else if (trig) begin
                if (busy) begin
                    pend <= 1'b1;
                end else begin
                    busy <= 1'b1;
                    ptr  <= BASE;
                    rem  <= max_cnt;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else if (eos && active && !seq_rst && (!irq_mode || eosb)) begin
            irq <= 1'b1;
        end else if (clr) begin
            irq <= 1'b0;
        end
    end
endmodule

// File: rtl/adc_seq_arb.sv
`timescale 1ns/1ps
module adc_seq_arb
    import adc_seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           busy,
    input  logic [SW-1:0]        ptr_a,
    input  logic [SW-1:0]        ptr_b,
    input  logic [SLOTS*CHW-1:0] chsel,
    input  logic [1:0]           seq_rst,
    input  logic                 conv_done,
    output logic                 conv_start,
    output logic [CHW-1:0]       conv_chan,
    output logic [1:0]           done_to,
    output logic [SW-1:0]        slot
);
    logic          out_q, keep_q, owner_q;
    logic          pick;
    logic [SW-1:0] pick_ptr;

    assign pick     = ~busy[0];
    assign pick_ptr = pick ? ptr_b : ptr_a;

    always_comb begin
        for (int i = 0; i < 2; i++) begin
            done_to[i] = conv_done && out_q && keep_q && (owner_q == i[0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q      <= 1'b0;
            keep_q     <= 1'b0;
            owner_q    <= 1'b0;
            slot       <= '0;
            conv_start <= 1'b0;
            conv_chan  <= '0;
        end else begin
            conv_start <= 1'b0;
            if (out_q) begin
                if (conv_done) out_q <= 1'b0;
                if (seq_rst[owner_q]) keep_q <= 1'b0;
            end else if (busy != 2'b00) begin
                out_q      <= 1'b1;
                keep_q     <= ~seq_rst[pick];
                owner_q    <= pick;
                slot       <= pick_ptr;
                conv_start <= 1'b1;
                conv_chan  <= chsel_field(chsel, pick_ptr);
            end
        end
    end
endmodule

// File: rtl/adc_seq_results.sv
`timescale 1ns/1ps
module adc_seq_results
    import adc_seq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [SW-1:0] slot,
    input  logic [DW-1:0] sample,
    input  logic [SW-1:0] rd_idx,
    output logic [RW-1:0] rd_data
);
    logic [RW-1:0] bank [SLOTS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOTS; i++) bank[i] <= '0;
        end else if (we) begin
            bank[slot] <= left_just(sample);
        end
    end

    assign rd_data = bank[rd_idx];
endmodule

// File: rtl/adc_autoseq.sv
`timescale 1ns/1ps
module adc_autoseq
    import adc_seq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [3:0]    wr_addr,
    input  logic [RW-1:0] wr_data,
    input  logic          ext_soc,
    input  logic          evt_a,
    input  logic          evt_b,
    output logic          conv_start,
    output logic [CHW-1:0] conv_chan,
    input  logic          conv_done,
    input  logic [DW-1:0] conv_data,
    input  logic [SW-1:0] rd_idx,
    output logic [RW-1:0] rd_data,
    output logic [1:0]    busy,
    output logic [1:0]    irq,
    output logic [1:0]    eos_buf,
    output logic [SW-1:0] ptr_a,
    output logic [SW-1:0] ptr_b,
    output logic [SW-1:0] remain_a,
    output logic [SW-1:0] remain_b
);
    logic                 cascade_q, cont_q;
    seq_cfg_t             cfg_q [2];
    logic [SLOTS*CHW-1:0] chsel_q;

    logic [1:0]    wr_ctl, trig, srst, clr_p, active, done_v, eos_v;
    logic [SW-1:0] ptr_v [2];
    logic [SW-1:0] rem_v [2];
    logic [SW-1:0] max_v [2];
    logic [SW-1:0] slot_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            cascade_q <= 1'b0;
            cont_q    <= 1'b0;
            cfg_q[0]  <= '0;
            cfg_q[1]  <= '0;
            chsel_q   <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_CFG) begin
                cascade_q <= wr_data[B_CASCADE];
                cont_q    <= wr_data[B_CONT];
            end
            for (int g = 0; g < 2; g++) begin
                if (wr_ctl[g]) cfg_q[g] <= ctl_decode(wr_data);
            end
            for (int r = 0; r < NCHREG; r++) begin
                if (wr_addr == ADDR_CHSEL + 4'(r)) chsel_q[r*RW +: RW] <= wr_data;
            end
        end
    end

    assign trig[0] = (wr_ctl[0] & wr_data[B_START]) | (ext_soc & cfg_q[0].ext_en)
                   | (evt_a & cfg_q[0].evt_en);
    assign trig[1] = (wr_ctl[1] & wr_data[B_START]) | (evt_b & cfg_q[1].evt_en);
    assign max_v[0] = cascade_q ? cfg_q[0].max_cnt : {1'b0, cfg_q[0].max_cnt[SW-2:0]};
    assign max_v[1] = {1'b0, cfg_q[1].max_cnt[SW-2:0]};
    assign active   = {~cascade_q, 1'b1};

    for (genvar g = 0; g < 2; g++) begin : g_seq
        assign wr_ctl[g] = wr_en && (wr_addr == ADDR_CTL_A + 4'(g));
        assign srst[g]   = wr_ctl[g] & wr_data[B_RESET];
        assign clr_p[g]  = wr_ctl[g] & wr_data[B_CLR];

        adc_seq_unit #(.BASE(SW'(g * HALF))) u_unit (
            .clk      (clk),
            .rst      (rst),
            .active   (active[g]),
            .trig     (trig[g]),
            .seq_rst  (srst[g]),
            .cont     (cont_q),
            .irq_mode (cfg_q[g].irq_mode),
            .clr      (clr_p[g]),
            .max_cnt  (max_v[g]),
            .done     (done_v[g]),
            .busy     (busy[g]),
            .ptr      (ptr_v[g]),
            .rem      (rem_v[g]),
            .irq      (irq[g]),
            .eosb     (eos_buf[g]),
            .eos      (eos_v[g])
        );
    end

    adc_seq_arb u_arb (
        .clk        (clk),
        .rst        (rst),
        .busy       (busy),
        .ptr_a      (ptr_v[0]),
        .ptr_b      (ptr_v[1]),
        .chsel      (chsel_q),
        .seq_rst    (srst),
        .conv_done  (conv_done),
        .conv_start (conv_start),
        .conv_chan  (conv_chan),
        .done_to    (done_v),
        .slot       (slot_w)
    );

    adc_seq_results u_res (
        .clk     (clk),
        .rst     (rst),
        .we      (|done_v),
        .slot    (slot_w),
        .sample  (conv_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    assign ptr_a    = ptr_v[0];
    assign ptr_b    = ptr_v[1];
    assign remain_a = rem_v[0];
    assign remain_b = rem_v[1];
endmodule

// File: rtl/adc_autoseq_chk.sv
`timescale 1ns/1ps
module adc_autoseq_chk
    import adc_seq_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          conv_start,
    input logic          conv_done,
    input logic [1:0]    busy,
    input logic          cascade,
    input logic [SW-1:0] rem_a,
    input logic [SW-1:0] rem_b,
    input logic [SW-1:0] ptr_b,
    input logic [1:0]    irq,
    input logic [1:0]    eos
);
    logic out_q;

    always_ff @(posedge clk) begin
        if (rst) out_q <= 1'b0;
        else if (conv_start) out_q <= 1'b1;
        else if (conv_done) out_q <= 1'b0;
    end

    assert_single_request_R13: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> !out_q);
    assert_start_is_pulse_R13: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);
    assert_b_idle_cascaded_R1: assert property (@(posedge clk) disable iff (rst)
        cascade |=> !busy[1]);
    assert_idle_count_a_R5: assert property (@(posedge clk) disable iff (rst)
        !busy[0] |-> rem_a == '0);
    assert_idle_count_b_R5: assert property (@(posedge clk) disable iff (rst)
        !busy[1] |-> rem_b == '0);
    assert_ptr_b_range_R5: assert property (@(posedge clk) disable iff (rst)
        ptr_b >= SW'(HALF));
    assert_irq_a_on_eos_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(irq[0]) |-> $past(eos[0]));
    assert_irq_b_on_eos_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(irq[1]) |-> $past(eos[1]));
endmodule

bind adc_autoseq adc_autoseq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .conv_start (conv_start),
    .conv_done  (conv_done),
    .busy       (busy),
    .cascade    (cascade_q),
    .rem_a      (remain_a),
    .rem_b      (remain_b),
    .ptr_b      (ptr_b),
    .irq        (irq),
    .eos        (eos_v)
);

// File: tb/adc_autoseq_tb.sv
`timescale 1ns/1ps
module adc_autoseq_tb;
    localparam int LAT = 3;
    localparam int LOGN = 512;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        ext_soc = 1'b0, evt_a = 1'b0, evt_b = 1'b0;
    logic        conv_start;
    logic [3:0]  conv_chan;
    logic        conv_done = 1'b0;
    logic [11:0] conv_data = '0;
    logic [3:0]  rd_idx = '0;
    logic [15:0] rd_data;
    logic [1:0]  busy, irq, eos_buf;
    logic [3:0]  ptr_a, ptr_b, remain_a, remain_b;

    int checks = 0, errors = 0;
    int nconv = 0;
    bit cv_busy = 1'b0;
    int log_chan [LOGN];
    int log_pa [LOGN];
    int log_pb [LOGN];
    int log_ra [LOGN];
    int log_data [LOGN];

    always #2 clk = ~clk;

    adc_autoseq u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ext_soc(ext_soc), .evt_a(evt_a), .evt_b(evt_b),
        .conv_start(conv_start), .conv_chan(conv_chan),
        .conv_done(conv_done), .conv_data(conv_data),
        .rd_idx(rd_idx), .rd_data(rd_data),
        .busy(busy), .irq(irq), .eos_buf(eos_buf),
        .ptr_a(ptr_a), .ptr_b(ptr_b), .remain_a(remain_a), .remain_b(remain_b)
    );

    function automatic int chan_of(int s);
        return (s * 7 + 3) % 16;
    endfunction

    function automatic logic [15:0] ctlw(bit ext, bit evt, bit mode, int mx,
                                         bit st, bit rs, bit cl);
        logic [15:0] w = '0;
        w[0] = st; w[1] = rs; w[2] = ext; w[3] = evt; w[4] = mode; w[5] = cl;
        w[11:8] = 4'(mx);
        return w;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) ext_soc = 1'b1;
        if (which == 1 || which == 3) evt_a = 1'b1;
        if (which == 2 || which == 3) evt_b = 1'b1;
        @(negedge clk);
        ext_soc = 1'b0; evt_a = 1'b0; evt_b = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (busy == 2'b00 && !cv_busy && !conv_start) break;
        end
    endtask

    task automatic rd_chk(input string req, input int slot, input int exp);
        rd_idx = 4'(slot);
        #1;
        chk(req, $sformatf("result slot %0d", slot), int'(rd_data), exp);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // converter model
    initial begin
        forever begin
            @(negedge clk);
            if (conv_start) begin
                cv_busy = 1'b1;
                if (nconv < LOGN) begin
                    log_chan[nconv] = int'(conv_chan);
                    log_pa[nconv]   = int'(ptr_a);
                    log_pb[nconv]   = int'(ptr_b);
                    log_ra[nconv]   = int'(remain_a);
                    log_data[nconv] = (nconv * 53 + int'(conv_chan) * 9 + 7) % 4096;
                end
                repeat (LAT) @(negedge clk);
                conv_data = 12'((nconv * 53 + log_chan[nconv % LOGN] * 9 + 7) % 4096);
                conv_done = 1'b1;
                @(negedge clk);
                conv_done = 1'b0;
                nconv++;
                cv_busy = 1'b0;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R6 watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        int n0, snap;
        logic [15:0] bank [16];

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        chk("R6", "busy after reset", int'(busy), 0);
        chk("R7", "irq after reset", int'(irq), 0);
        chk("R5", "ptr_a after reset", int'(ptr_a), 0);
        chk("R5", "ptr_b after reset", int'(ptr_b), 8);
        chk("R5", "remain after reset", int'(remain_a) + int'(remain_b), 0);
        chk("R13", "conv_start after reset", int'(conv_start), 0);
        rd_chk("R4", 0, 0);

        // channel selects (R2)
        for (int r = 0; r < 4; r++) begin
            logic [15:0] w = '0;
            for (int q = 0; q < 4; q++) w[q*4 +: 4] = 4'(chan_of(r * 4 + q));
            wr(4'(4 + r), w);
        end

        // cascaded sweep over every length (R1 R2 R3 R4 R5 R6 R7 R8)
        wr(4'd0, 16'h0001);
        for (int n = 0; n < 16; n++) begin
            wr(4'd1, ctlw(0, 0, 0, n, 0, 0, 0));
            n0 = nconv;
            wr(4'd1, ctlw(0, 0, 0, n, 1, 0, 0));
            chk("R6", "busy after start", int'(busy[0]), 1);
            wait_idle();
            chk("R3", $sformatf("conversions for N=%0d", n), nconv - n0, n + 1);
            for (int j = 0; j <= n; j++) begin
                chk("R2", "channel order", log_chan[n0 + j], chan_of(j));
                chk("R5", "pointer at request", log_pa[n0 + j], j);
                chk("R5", "remaining at request", log_ra[n0 + j], n - j);
                rd_chk("R4", j, log_data[n0 + j] * 16);
            end
            chk("R7", "irq at end (mode 0)", int'(irq[0]), 1);
            chk("R6", "busy at end", int'(busy[0]), 0);
            wr(4'd1, ctlw(0, 0, 0, n, 0, 0, 1));
            chk("R8", "irq after clear", int'(irq[0]), 0);
        end

        // cascaded: sequencer B ignores triggers (R1)
        wr(4'd2, ctlw(0, 1, 0, 2, 0, 0, 0));
        n0 = nconv;
        pulse(2);
        repeat (3) @(negedge clk);
        chk("R1", "B busy while cascaded", int'(busy[1]), 0);
        chk("R1", "no conversion from B", nconv - n0, 0);

        // split mode: both triggered together, A first, masked length (R12 R3 R4 R5)
        wr(4'd0, 16'h0000);
        wr(4'd1, ctlw(0, 1, 0, 10, 0, 0, 0));
        wr(4'd2, ctlw(0, 1, 0, 3, 0, 0, 0));
        n0 = nconv;
        pulse(3);
        wait_idle();
        chk("R3", "split conversions (A masked 3, B 4)", nconv - n0, 7);
        for (int j = 0; j < 3; j++) begin
            chk("R12", "A served first", log_chan[n0 + j], chan_of(j));
            rd_chk("R4", j, log_data[n0 + j] * 16);
        end
        for (int k = 0; k < 4; k++) begin
            chk("R2", "B channel", log_chan[n0 + 3 + k], chan_of(8 + k));
            chk("R5", "B pointer", log_pb[n0 + 3 + k], 8 + k);
            rd_chk("R4", 8 + k, log_data[n0 + 3 + k] * 16);
        end
        chk("R7", "both irq", int'(irq), 3);
        wr(4'd1, ctlw(0, 0, 0, 0, 0, 0, 1));
        wr(4'd2, ctlw(0, 0, 0, 0, 0, 0, 1));
        chk("R8", "both cleared", int'(irq), 0);

        // interrupt every second end (R7 R8)
        wr(4'd1, ctlw(0, 0, 1, 0, 0, 0, 0));
        wr(4'd1, ctlw(0, 0, 1, 0, 1, 0, 0));
        wait_idle();
        chk("R7", "mode1 first end irq", int'(irq[0]), 0);
        chk("R7", "mode1 first end buf", int'(eos_buf[0]), 1);
        wr(4'd1, ctlw(0, 0, 1, 0, 1, 0, 0));
        wait_idle();
        chk("R7", "mode1 second end irq", int'(irq[0]), 1);
        chk("R7", "mode1 second end buf", int'(eos_buf[0]), 0);
        wr(4'd1, ctlw(0, 0, 1, 0, 0, 0, 0));
        chk("R8", "write without clear keeps irq", int'(irq[0]), 1);
        wr(4'd1, ctlw(0, 0, 0, 0, 0, 0, 1));
        chk("R8", "clear after mode1", int'(irq[0]), 0);

        // external pin gating (R10)
        n0 = nconv;
        pulse(0);
        repeat (3) @(negedge clk);
        chk("R10", "ext pin disabled busy", int'(busy[0]), 0);
        chk("R10", "ext pin disabled conversions", nconv - n0, 0);
        wr(4'd1, ctlw(1, 0, 0, 0, 0, 0, 0));
        pulse(0);
        chk("R10", "ext pin enabled busy", int'(busy[0]), 1);
        wait_idle();
        chk("R10", "ext pin enabled conversions", nconv - n0, 1);

        // pending trigger while busy (R12)
        wr(4'd1, ctlw(0, 0, 0, 3, 0, 0, 0));
        n0 = nconv;
        wr(4'd1, ctlw(0, 0, 0, 3, 1, 0, 0));
        repeat (2) @(negedge clk);
        wr(4'd1, ctlw(0, 0, 0, 3, 1, 0, 0));
        wait_idle();
        chk("R12", "held trigger reruns", nconv - n0, 8);

        // continuous running, then sequencer reset (R11 R9)
        wr(4'd0, 16'h0002);
        wr(4'd1, ctlw(0, 0, 0, 1, 0, 0, 0));
        n0 = nconv;
        wr(4'd1, ctlw(0, 0, 0, 1, 1, 0, 0));
        for (int i = 0; i < 5000 && nconv - n0 < 6; i++) @(negedge clk);
        chk("R11", "still busy after several sequences", int'(busy[0]), 1);
        for (int j = 0; j < 6; j++)
            chk("R11", "restart order", log_chan[n0 + j], chan_of(j % 2));
        wr(4'd1, ctlw(0, 0, 0, 1, 0, 1, 0));
        chk("R9", "busy after reset", int'(busy[0]), 0);
        chk("R9", "pointer after reset", int'(ptr_a), 0);
        chk("R9", "remaining after reset", int'(remain_a), 0);
        snap = nconv + (cv_busy ? 1 : 0);
        for (int i = 0; i < 16; i++) begin
            rd_idx = 4'(i);
            #1;
            bank[i] = rd_data;
        end
        repeat (30) @(negedge clk);
        chk("R9", "no new conversions after reset", nconv, snap);
        for (int i = 0; i < 16; i++) rd_chk("R9", i, int'(bank[i]));
        wr(4'd0, 16'h0000);

        finish_run();
    end
endmodule